// File: doc/BRIEF.md
# Three-Wire Serial Register Programmer

This block is the master of a three-wire control bus: a frame strobe that is active low, a serial clock, and a bidirectional data line. It writes and reads 16-bit registers in an attached frequency-synthesizer device. A host issues a one-cycle start strobe together with a direction flag, a 7-bit register address and, for writes, 16 bits of data. The block turns that request into a complete serial frame and builds the serial clock from the system clock. For reads it turns the data line around and assembles the returned word. The data line is modelled as three separate signals: the driven value, its output enable, and the received value.

At power-up the block holds the device's reset pin low for a programmable number of system clocks. During that time the bus is parked idle. It then releases the reset pin, and only after that does it accept transfers. The device's chip-enable pin follows a host request once the power-up sequence has finished.

Every serial clock phase lasts `HALF_CYC` system clocks. The integrator picks this value so that each half-period and each data setup interval is at least 30 ns.

Top module: `twsp_top`

## Requirements
- R1: After `rst_n` is released, `dev_rst_n_o` stays low for at least `RST_CYC` and at most `RST_CYC+4` system clocks. While it is low, `sel_n_o`=1, `sclk_o`=0, `sdo_o`=0 and `sdo_oe_o`=1, and any start strobe is ignored.
- R2: Within a frame, every high phase and every low phase of `sclk_o` lasts exactly `HALF_CYC` system clocks.
- R3: A frame opens with exactly one `sclk_o` pulse while `sel_n_o` is still high. `sel_n_o` then falls while `sclk_o` is low.
- R4: The first payload bit is the direction bit (0 = write, 1 = read), followed by the 7 address bits, MSB first. The device takes each bit on a rising `sclk_o`. One `sclk_o` pulse with `sdo_o`=0 comes after the fall of `sel_n_o` and before the direction bit.
- R5: On a write, 16 data bits follow the address, MSB first. `sdo_o` changes only while `sclk_o` is low, and never on the cycle in which `sclk_o` rises.
- R6: On a read, one more `sclk_o` high phase follows the last address bit while `sdo_oe_o` is still 1. `sdo_oe_o` then drops and one further low/high `sclk_o` cycle comes before the data phase. This gives 27 rising edges with `sel_n_o` low, 17 of them with `sdo_oe_o`=0.
- R7: On a read, `sdi_i` is sampled during each of 16 `sclk_o` low phases, just before the rising edge. Bits are shifted into the LSB end, so the first bit lands in the MSB. `rdata_o` holds the result when `done_o` pulses.
- R8: After the last data bit, `sel_n_o` rises while `sclk_o` is low. Exactly one tidy-up `sclk_o` pulse follows, and the bus ends with `sclk_o`=0 and `sdo_oe_o`=1.
- R9: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` is a single-cycle pulse with `busy_o` low. A start strobe while `busy_o` is high is ignored and produces no second frame.
- R10: `sdo_oe_o` is 0 only during a read's turnaround and data phase, for exactly 34*`HALF_CYC` system clocks, and always with `sel_n_o` low. It stays 1 for a whole write frame.
- R11: `dev_en_o` is 0 until the power-up sequence completes. After that it follows `chip_en_i` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| chip_en_i | input | 1 | Requested state of the device enable pin |
| rdata_o | output | DATA_W | Assembled read word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock |
| sel_n_o | output | 1 | Frame strobe, active low |
| sdo_o | output | 1 | Serial data driven to the device |
| sdo_oe_o | output | 1 | Output enable for the data line |
| sdi_i | input | 1 | Serial data received from the device |
| dev_rst_n_o | output | 1 | Device reset, active low |
| dev_en_o | output | 1 | Device enable |

## Verification
The bench builds the block with `HALF_CYC`=3 and `RST_CYC`=8. At these values a frame takes under 200 system clocks, so every one of the 128 addresses can be written and read back within the cycle budget. The write and read words are computed from the address and include the all-zero and all-one patterns. The bench acts as the device itself: it collects the bits on rising clock edges, drives read bits on falling edges, and measures every clock phase. Some frames also receive a second start strobe in the middle of the frame, which exercises the rule that starts during a busy transfer are ignored.

// File: rtl/twsp_pkg.sv
package twsp_pkg;

  // Registered three-wire bus pin bundle
  typedef struct packed {
    logic sclk;
    logic sel_n;
    logic sdo;
    logic oe;
  } bus_pins_t;

  localparam bus_pins_t BUS_IDLE = '{sclk: 1'b0, sel_n: 1'b1, sdo: 1'b0, oe: 1'b1};

endpackage

// File: rtl/twsp_half_timer.sv
module twsp_half_timer #(
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  half_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/twsp_powerup.sv
module twsp_powerup #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic dev_rst_n,
  output logic init_done
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] HOLD = CW'(RST_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != HOLD) cnt_d = cnt_q + 1'b1;
    rel_d = (cnt_q == HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign dev_rst_n = rel_q;
  assign init_done = rel_q;

  // R1
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> rel_q);

endmodule

// File: rtl/twsp_frame_engine.sv
module twsp_frame_engine
  import twsp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output bus_pins_t         pins_o
);
  localparam int HDR_W      = 1 + ADDR_W;
  localparam int FRM_W      = HDR_W + DATA_W;
  localparam int S_BIT0     = 3;
  localparam int S_HDR_END  = S_BIT0 + 2 * HDR_W;
  localparam int S_TURN_OFF = S_HDR_END + 2;
  localparam int S_RD0      = S_HDR_END + 4;
  localparam int S_END_W    = S_HDR_END + 2 * DATA_W;
  localparam int S_END_R    = S_RD0 + 2 * DATA_W;
  localparam int S_LAST_W   = S_END_W + 2;
  localparam int S_LAST_R   = S_END_R + 2;
  localparam int SLOT_W     = $clog2(S_LAST_R + 1);

  localparam logic [SLOT_W-1:0] L_BIT0     = SLOT_W'(S_BIT0);
  localparam logic [SLOT_W-1:0] L_HDR_END  = SLOT_W'(S_HDR_END);
  localparam logic [SLOT_W-1:0] L_TURN_OFF = SLOT_W'(S_TURN_OFF);
  localparam logic [SLOT_W-1:0] L_RD0      = SLOT_W'(S_RD0);
  localparam logic [SLOT_W-1:0] L_END_W    = SLOT_W'(S_END_W);
  localparam logic [SLOT_W-1:0] L_END_R    = SLOT_W'(S_END_R);
  localparam logic [SLOT_W-1:0] L_LAST_W   = SLOT_W'(S_LAST_W);
  localparam logic [SLOT_W-1:0] L_LAST_R   = SLOT_W'(S_LAST_R);

  logic              busy_q, busy_d;
  logic              rd_q, rd_d;
  logic              done_q, done_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [FRM_W-1:0]  shift_q, shift_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [SLOT_W-1:0] last_slot, end_slot;

  assign last_slot = rd_q ? L_LAST_R : L_LAST_W;
  assign end_slot  = rd_q ? L_END_R  : L_END_W;

  // Next-state logic: one slot per clock half-period
  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    slot_d  = slot_q;
    shift_d = shift_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        rd_d    = rd_i;
        slot_d  = '0;
        shift_d = {rd_i, addr_i, (rd_i ? {DATA_W{1'b0}} : wdata_i)};
        if (rd_i) rdata_d = '0;
      end
    end else if (tick_i) begin
      if (slot_q == last_slot) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
      end
      // advance the transmit word at the end of each high slot
      if (!slot_q[0] && (slot_q > L_BIT0))
        shift_d = {shift_q[FRM_W-2:0], 1'b0};
      // capture at the end of each low slot of the read data phase
      if (rd_q && slot_q[0] && (slot_q >= L_RD0) && (slot_q < L_END_R))
        rdata_d = {rdata_q[DATA_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      slot_q  <= '0;
      shift_q <= '0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      slot_q  <= slot_d;
      shift_q <= shift_d;
      rdata_q <= rdata_d;
    end
  end

  // Pin decode from the current slot (even slots are clock-high)
  always_comb begin
    pins_o       = BUS_IDLE;
    pins_o.sclk  = busy_q & ~slot_q[0];
    pins_o.sel_n = ~(busy_q && (slot_q != '0) && (slot_q < end_slot));
    pins_o.sdo   = busy_q && (slot_q >= L_BIT0) &&
                   (!rd_q || (slot_q < L_HDR_END)) && shift_q[FRM_W-1];
    pins_o.oe    = ~(busy_q && rd_q && (slot_q >= L_TURN_OFF) && (slot_q < L_END_R));
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !tick_i) |=> ($stable(rd_q) && $stable(shift_q) && $stable(slot_q)));

endmodule

// File: rtl/twsp_top.sv
module twsp_top
  import twsp_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int HALF_CYC = 3,
  parameter int RST_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              chip_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              sel_n_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i,
  output logic              dev_rst_n_o,
  output logic              dev_en_o
);
  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       init_done;
  logic       tick;
  logic       start_ok;
  logic       dev_en_q, dev_en_d;
  bus_pins_t  pins_d, pins_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  twsp_powerup #(.RST_CYC(RST_CYC)) u_powerup (
    .clk       (clk),
    .rst_n     (srst_n),
    .dev_rst_n (dev_rst_n_o),
    .init_done (init_done)
  );

  twsp_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (busy_o),
    .tick  (tick)
  );

  assign start_ok = start_i && init_done;

  twsp_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (start_ok),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .tick_i  (tick),
    .sdi_i   (sdi_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rdata_o (rdata_o),
    .pins_o  (pins_d)
  );

  assign dev_en_d = init_done && chip_en_i;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pins_q   <= BUS_IDLE;
      dev_en_q <= 1'b0;
    end else begin
      pins_q   <= pins_d;
      dev_en_q <= dev_en_d;
    end
  end

  assign sclk_o   = pins_q.sclk;
  assign sel_n_o  = pins_q.sel_n;
  assign sdo_o    = pins_q.sdo;
  assign sdo_oe_o = pins_q.oe;
  assign dev_en_o = dev_en_q;

  // R1
  parked_in_reset_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !dev_rst_n_o |-> (sel_n_o && !sclk_o && sdo_oe_o));
  // R2
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sclk_o) |=> sclk_o);
  // R3
  sel_fall_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(sel_n_o) |-> !sclk_o);
  // R8
  sel_rise_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sel_n_o) |-> !sclk_o);
  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sclk_o) |-> $stable(sdo_o));
  // R10
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !sdo_oe_o |-> !sel_n_o);
  // R11
  en_after_init_chk: assert property (@(posedge clk) disable iff (!srst_n)
    dev_en_o |-> dev_rst_n_o);

endmodule

// File: tb/twsp_top_bench.sv
module twsp_top_bench;
  localparam int CLK_PER = 10;
  localparam int HALF    = 3;
  localparam int RSTC    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        chip_en_i = 1'b0;
  logic        sdi_drv = 1'b0;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, sclk_o, sel_n_o, sdo_o, sdo_oe_o, dev_rst_n_o, dev_en_o;

  always #(CLK_PER/2) clk = ~clk;

  twsp_top #(.ADDR_W(7), .DATA_W(16), .HALF_CYC(HALF), .RST_CYC(RSTC)) u_twsp_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .chip_en_i(chip_en_i), .rdata_o(rdata_o), .busy_o(busy_o),
    .done_o(done_o), .sclk_o(sclk_o), .sel_n_o(sel_n_o), .sdo_o(sdo_o),
    .sdo_oe_o(sdo_oe_o), .sdi_i(sdi_drv), .dev_rst_n_o(dev_rst_n_o), .dev_en_o(dev_en_o)
  );

  int total = 0;
  int bad = 0;

  // device-side monitor state
  bit          mon_on = 0;
  logic        p_sclk = 1'b0, p_sel = 1'b1, p_sdo = 1'b0;
  int          n_rise_pre, n_rise_post, n_rise_lo, n_rise_oelo;
  int          n_sel_fall, n_selfall_hi, n_selrise_hi, n_sdo_bad;
  int          n_oe_lo, n_oe_bad, n_done, n_done_busy;
  int          hi_min, hi_max, lo_min, lo_max, run_len, fidx;
  bit          seen_rise, seen_low;
  logic [31:0] cap;
  logic [15:0] rv_cur;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_rise_pre = 0; n_rise_post = 0; n_rise_lo = 0; n_rise_oelo = 0;
    n_sel_fall = 0; n_selfall_hi = 0; n_selrise_hi = 0; n_sdo_bad = 0;
    n_oe_lo = 0; n_oe_bad = 0; n_done = 0; n_done_busy = 0;
    hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0; run_len = 0; fidx = 0;
    seen_rise = 0; seen_low = 0; cap = '0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (sclk_o && !p_sclk) begin
        if (sel_n_o) begin
          if (seen_low) n_rise_post++; else n_rise_pre++;
        end else begin
          n_rise_lo++;
          cap = {cap[30:0], sdo_o};
        end
        if (!sdo_oe_o) n_rise_oelo++;
        if (sdo_o != p_sdo) n_sdo_bad++;
        if (seen_rise) begin
          if (run_len < lo_min) lo_min = run_len;
          if (run_len > lo_max) lo_max = run_len;
        end
        seen_rise = 1;
        run_len = 1;
      end else if (!sclk_o && p_sclk) begin
        if (run_len < hi_min) hi_min = run_len;
        if (run_len > hi_max) hi_max = run_len;
        run_len = 1;
        if (!sdo_oe_o) begin
          if (fidx >= 1 && fidx <= 16) sdi_drv = rv_cur[16 - fidx];
          fidx++;
        end
      end else begin
        run_len++;
        if (sclk_o && (sdo_o != p_sdo)) n_sdo_bad++;
      end
      if (!sel_n_o && p_sel) begin
        n_sel_fall++;
        seen_low = 1;
        if (sclk_o) n_selfall_hi++;
      end
      if (sel_n_o && !p_sel && sclk_o) n_selrise_hi++;
      if (!sdo_oe_o) begin
        n_oe_lo++;
        if (sel_n_o) n_oe_bad++;
      end
      if (done_o) begin
        n_done++;
        if (busy_o) n_done_busy++;
      end
    end
    p_sclk = sclk_o;
    p_sel  = sel_n_o;
    p_sdo  = sdo_o;
  end

  task automatic run_frame(input logic rd, input logic [6:0] a, input logic [15:0] wd,
                           input logic [15:0] rv, input bit poke);
    int busy_gap;
    int k;
    clear_mon();
    rv_cur  = rv;
    sdi_drv = 1'b0;
    busy_gap = 0;
    @(negedge clk);
    start_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = wd;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    k = 0;
    while (!done_o && k < 1000) begin
      if (!busy_o) busy_gap++;
      if (poke && k == 20) begin
        start_i = 1'b1; rd_i = ~rd; addr_i = ~a; wdata_i = ~wd;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    chk(k < 1000, "R9 done reached", k, 0);
    repeat (3) @(negedge clk);
    chk(busy_gap == 0, "R9 busy held", busy_gap, 0);
    chk(n_done == 1 && n_done_busy == 0, "R9 single done", n_done, 1);
    chk(n_sel_fall == 1 && busy_o == 1'b0, "R9 one frame only", n_sel_fall, 1);
    chk(n_rise_pre == 1 && n_selfall_hi == 0, "R3 opening pulse", n_rise_pre, 1);
    chk(n_rise_post == 1 && n_selrise_hi == 0, "R8 tidy pulse", n_rise_post, 1);
    chk(sclk_o == 1'b0 && sel_n_o == 1'b1 && sdo_oe_o == 1'b1, "R8 idle after frame",
        {sclk_o, sel_n_o, sdo_oe_o}, 3'b011);
    chk(hi_min == HALF && hi_max == HALF, "R2 high phase", hi_max, HALF);
    chk(lo_min == HALF && lo_max == HALF, "R2 low phase", lo_max, HALF);
    chk(n_sdo_bad == 0, "R5 data stable around rise", n_sdo_bad, 0);
    chk(n_oe_bad == 0, "R10 oe outside frame", n_oe_bad, 0);
    if (!rd) begin
      chk(n_rise_lo == 25, "R4 write edge count", n_rise_lo, 25);
      chk(cap[24:0] == {2'b00, a, wd}, "R5 write bits", int'(cap[24:0]),
          int'({2'b00, a, wd}));
      chk(n_oe_lo == 0, "R10 oe in write", n_oe_lo, 0);
    end else begin
      chk(n_rise_lo == 27, "R6 read edge count", n_rise_lo, 27);
      chk(n_rise_oelo == 17, "R6 turnaround edges", n_rise_oelo, 17);
      chk(cap[26:18] == {2'b01, a}, "R4 read header", int'(cap[26:18]),
          int'({2'b01, a}));
      chk(n_oe_lo == 34 * HALF, "R10 oe low length", n_oe_lo, 34 * HALF);
      chk(rdata_o == rv, "R7 read word", rdata_o, rv);
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lowcnt;
    int init_bad;
    int en_bad;
    clear_mon();
    chip_en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(dev_rst_n_o == 1'b0 && sel_n_o == 1'b1 && sclk_o == 1'b0 && sdo_oe_o == 1'b1,
        "R1 reset state", {dev_rst_n_o, sel_n_o, sclk_o, sdo_oe_o}, 4'b0101);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R9 reset idle", busy_o, 0);
    chk(dev_en_o == 1'b0, "R11 enable low in reset", dev_en_o, 0);
    rst_n = 1'b1;
    mon_on = 1;
    lowcnt = 0; init_bad = 0; en_bad = 0;
    while (!dev_rst_n_o && lowcnt < 100) begin
      lowcnt++;
      if (!sel_n_o || sclk_o || sdo_o || !sdo_oe_o) init_bad++;
      if (dev_en_o) en_bad++;
      start_i = (lowcnt == 4);
      rd_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(lowcnt >= RSTC && lowcnt <= RSTC + 4, "R1 reset hold length", lowcnt, RSTC);
    chk(init_bad == 0, "R1 bus parked", init_bad, 0);
    chk(en_bad == 0, "R11 enable held low", en_bad, 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && n_sel_fall == 0, "R1 early start ignored", n_sel_fall, 0);
    chk(dev_en_o == 1'b1, "R11 enable follows", dev_en_o, 1);
    chip_en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(dev_en_o == 1'b0, "R11 enable drops", dev_en_o, 0);

    run_frame(1'b0, 7'h00, 16'h0000, 16'h0, 1'b0);
    run_frame(1'b0, 7'h7F, 16'hFFFF, 16'h0, 1'b0);
    run_frame(1'b1, 7'h55, 16'h0, 16'hFFFF, 1'b0);
    run_frame(1'b1, 7'h2A, 16'h0, 16'h0000, 1'b0);
    for (int a = 0; a < 128; a++) begin
      logic [15:0] wd;
      wd = 16'(a * 16'h0203) ^ 16'hA55A;
      run_frame(1'b0, 7'(a), wd, 16'h0, (a % 16) == 5);
    end
    for (int a = 0; a < 128; a++) begin
      logic [15:0] rv;
      rv = 16'(a * 16'h1357) ^ 16'hC3A5;
      run_frame(1'b1, 7'(a), 16'h0, rv, (a % 16) == 9);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule